// File: doc/BRIEF.md
# Asynchronous SRAM interface controller

This block lets a clocked system use a 32K x 8 asynchronous static RAM that has a shared bidirectional data bus. On its user side it takes one request at a time: an address, a write flag and a write byte, sampled while `ready` is high. It runs the SRAM's active-low select, output-enable and write-strobe pins through a fixed sequence of clock-cycle phases. For a read it returns the captured byte with a one-cycle `rd_valid` pulse.

Each phase length is a parameter given in nanoseconds. At elaboration it is converted to whole clock cycles by rounding up at the configured clock period. The phases cover the access time, write pulse, data setup before the write-ending edge and bus float time. The write window is bounded by the write strobe inside a longer select window. The controller drives the data bus only after the SRAM's outputs have had time to float. It keeps driving the bus until one cycle after the write strobe rises. Whenever no request is being served, all three strobes sit high, which leaves the SRAM deselected in its low-power state.

Top module: `async_sram_ctrl`

## Requirements
- R1: During reset and in every cycle where `ready` is high, the select, output-enable and write-strobe pins are all high (1), and the controller does not drive the data bus.
- R2: A request is taken only at a clock edge where `ready` is high. A `req` pulse that starts and ends while `ready` is low does not change the memory and does not lengthen the operation in progress.
- R3: In a write, select goes low together with the address and leads the write-strobe fall by C_AS cycles (1 at defaults). The write strobe then stays low for C_TURN + C_SD cycles (4 + 5 = 9 at defaults). Output-enable stays high and select stays low for that whole time.
- R4: The write byte appears on the bus only after the write strobe has been low for C_TURN cycles, and the controller never drives while output-enable is low. The byte is held unchanged for at least C_SD cycles before the write strobe rises, and the controller keeps driving it through the cycle after that rise.
- R5: A write ends on the rising edge of the write strobe while select is still low. Select rises exactly one cycle later.
- R6: In a read, select and output-enable are low together for C_RD cycles (11 at defaults) while the write strobe stays high. The byte on the bus is captured at the end of the last of those cycles and presented on `rd_data`.
- R7: `rd_valid` is high for exactly one cycle: the first cycle in which output-enable is high again after a read. `rd_data` keeps the captured byte afterwards.
- R8: `ready` stays low for the whole cycle time: 12 cycles for a write and 15 for a read at defaults. A read's tail is never shorter than C_TURN, so the SRAM has floated before any later write drives the bus.
- R9: `sram_addr` stays constant from the edge that takes a request until `ready` returns.
- R10: Every cycle count is the nanosecond figure divided by the clock period and rounded up, with the limits below. C_TURN comes from the float time. C_SD is large enough for both the data setup and the write pulse width. C_AS tops up the address-to-write-end time. C_RD comes from the access time. Each tail fills up to the minimum cycle time. Every count is at least 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Request, sampled while ready is high |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Word address of the request |
| req_wdata | input | 8 | Byte to write |
| ready | output | 1 | High when a new request can be taken |
| rd_valid | output | 1 | One-cycle pulse when rd_data is fresh |
| rd_data | output | 8 | Byte captured by the last read |
| sram_addr | output | 15 | Address pins of the SRAM |
| sram_ce_n | output | 1 | Active-low chip select |
| sram_oe_n | output | 1 | Active-low output enable |
| sram_we_n | output | 1 | Active-low write strobe |
| sram_dq | inout | 8 | Shared data bus |

## Verification
Two events can land in the same cycle: `ready` coming back at the end of one operation, and the next request being taken. The bench provokes this by raising `req` for the next operation while the current one is still busy and holding it high. The request must then be taken at the first edge where `ready` is high, exactly once, with its own address on the pins and no overlap with the previous strobes. The scoreboard judges the result by read data and by the busy-cycle count of each operation. A short `req` pulse placed wholly inside a busy window must, in contrast, leave both the memory contents and that count unchanged.

// File: rtl/sram_ctl_pkg.sv
`timescale 1ns/1ps
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WSET,
    ST_WTURN,
    ST_WDATA,
    ST_WHOLD,
    ST_RACC,
    ST_TAIL
  } ctl_state_e;

  typedef struct packed {
    logic ce_n;
    logic oe_n;
    logic we_n;
    logic drive;
  } pin_set_t;

  localparam pin_set_t PINS_QUIET = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, drive: 1'b0};

  // nanoseconds to whole clock cycles, rounded up
  function automatic int ns_to_cyc(int ns, int clk_ps);
    return (ns * 1000 + clk_ps - 1) / clk_ps;
  endfunction

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  // pin levels held during each phase
  function automatic pin_set_t pins_for(ctl_state_e s);
    pin_set_t p;
    p = PINS_QUIET;
    case (s)
      ST_WSET:  p = '{ce_n: 1'b0, oe_n: 1'b1, we_n: 1'b1, drive: 1'b0};
      ST_WTURN: p = '{ce_n: 1'b0, oe_n: 1'b1, we_n: 1'b0, drive: 1'b0};
      ST_WDATA: p = '{ce_n: 1'b0, oe_n: 1'b1, we_n: 1'b0, drive: 1'b1};
      ST_WHOLD: p = '{ce_n: 1'b0, oe_n: 1'b1, we_n: 1'b1, drive: 1'b1};
      ST_RACC:  p = '{ce_n: 1'b0, oe_n: 1'b0, we_n: 1'b1, drive: 1'b0};
      default:  p = PINS_QUIET;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/sram_ctl_timer.sv
`timescale 1ns/1ps
module sram_ctl_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/sram_ctl_seq.sv
`timescale 1ns/1ps
module sram_ctl_seq import sram_ctl_pkg::*; #(
  parameter int CNT_W   = 4,
  parameter int C_AS    = 1,
  parameter int C_TURN  = 4,
  parameter int C_SD    = 5,
  parameter int C_RD    = 11,
  parameter int C_WTAIL = 1,
  parameter int C_RTAIL = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             req_we,
  input  logic             tmr_zero,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             ev_accept,
  output logic             ev_capture,
  output logic             ready,
  output pin_set_t         pins_q
);

  ctl_state_e state_q, state_d;

  always_comb begin
    state_d    = state_q;
    tmr_load   = 1'b0;
    tmr_val    = '0;
    ev_accept  = 1'b0;
    ev_capture = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (req) begin
          ev_accept = 1'b1;
          tmr_load  = 1'b1;
          if (req_we) begin
            state_d = ST_WSET;
            tmr_val = CNT_W'(C_AS - 1);
          end else begin
            state_d = ST_RACC;
            tmr_val = CNT_W'(C_RD - 1);
          end
        end
      end
      ST_WSET: begin
        if (tmr_zero) begin
          state_d  = ST_WTURN;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(C_TURN - 1);
        end
      end
      ST_WTURN: begin
        if (tmr_zero) begin
          state_d  = ST_WDATA;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(C_SD - 1);
        end
      end
      ST_WDATA: begin
        if (tmr_zero) begin
          state_d  = ST_WHOLD;
          tmr_load = 1'b1;
          tmr_val  = '0;
        end
      end
      ST_WHOLD: begin
        state_d  = ST_TAIL;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(C_WTAIL - 1);
      end
      ST_RACC: begin
        if (tmr_zero) begin
          ev_capture = 1'b1;
          state_d    = ST_TAIL;
          tmr_load   = 1'b1;
          tmr_val    = CNT_W'(C_RTAIL - 1);
        end
      end
      ST_TAIL: begin
        if (tmr_zero) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // pins are registered from the next state so they change glitch-free at the edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pins_q  <= PINS_QUIET;
    end else begin
      state_q <= state_d;
      pins_q  <= pins_for(state_d);
    end
  end

  assign ready = (state_q == ST_IDLE);

  AST_NO_START_WITHOUT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    ready && !req |=> ready); // R2

  AST_CAPTURE_IN_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_capture |-> !pins_q.oe_n && !pins_q.ce_n); // R6

endmodule

// File: rtl/sram_ctl_edge.sv
`timescale 1ns/1ps
module sram_ctl_edge #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_accept,
  input  logic              ev_capture,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] dq_in,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [DATA_W-1:0] rd_data_q,
  output logic              rd_valid_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (ev_accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data_q  <= '0;
      rd_valid_q <= 1'b0;
    end else begin
      rd_valid_q <= ev_capture;
      if (ev_capture) rd_data_q <= dq_in;
    end
  end

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_q |=> !rd_valid_q); // R7

  AST_RDATA_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_capture |=> $stable(rd_data_q)); // R7

endmodule

// File: rtl/async_sram_ctrl.sv
`timescale 1ns/1ps
module async_sram_ctrl import sram_ctl_pkg::*; #(
  parameter int ADDR_W    = 15,
  parameter int DATA_W    = 8,
  parameter int CLK_PS    = 5000,
  parameter int T_ACC_NS  = 55,
  parameter int T_RC_NS   = 55,
  parameter int T_WC_NS   = 55,
  parameter int T_AW_NS   = 45,
  parameter int T_WP_NS   = 40,
  parameter int T_SD_NS   = 25,
  parameter int T_HZ_NS   = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              ready,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_ce_n,
  output logic              sram_oe_n,
  output logic              sram_we_n,
  inout  wire  [DATA_W-1:0] sram_dq
);

  // phase lengths in cycles (R10)
  localparam int C_TURN  = imax(1, ns_to_cyc(T_HZ_NS, CLK_PS));
  localparam int C_SD    = imax(1, imax(ns_to_cyc(T_SD_NS, CLK_PS),
                                        ns_to_cyc(T_WP_NS, CLK_PS) - C_TURN));
  localparam int C_AS    = imax(1, ns_to_cyc(T_AW_NS, CLK_PS) - C_TURN - C_SD);
  localparam int C_RD    = imax(1, ns_to_cyc(T_ACC_NS, CLK_PS));
  localparam int C_WTAIL = imax(1, ns_to_cyc(T_WC_NS, CLK_PS) - (C_AS + C_TURN + C_SD + 1));
  localparam int C_RTAIL = imax(C_TURN, ns_to_cyc(T_RC_NS, CLK_PS) - C_RD);
  localparam int C_MAX   = imax(imax(imax(C_TURN, C_SD), imax(C_AS, C_RD)),
                                imax(C_WTAIL, C_RTAIL));
  localparam int CNT_W   = $clog2(C_MAX + 1);

  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_zero;
  logic             ev_accept;
  logic             ev_capture;
  pin_set_t         pins_q;
  logic             drv_en;
  logic [DATA_W-1:0] wdata_q;

  sram_ctl_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  sram_ctl_seq #(
    .CNT_W   (CNT_W),
    .C_AS    (C_AS),
    .C_TURN  (C_TURN),
    .C_SD    (C_SD),
    .C_RD    (C_RD),
    .C_WTAIL (C_WTAIL),
    .C_RTAIL (C_RTAIL)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req        (req),
    .req_we     (req_we),
    .tmr_zero   (tmr_zero),
    .tmr_load   (tmr_load),
    .tmr_val    (tmr_val),
    .ev_accept  (ev_accept),
    .ev_capture (ev_capture),
    .ready      (ready),
    .pins_q     (pins_q)
  );

  sram_ctl_edge #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_edge (
    .clk        (clk),
    .rst_n      (rst_n),
    .ev_accept  (ev_accept),
    .ev_capture (ev_capture),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .dq_in      (sram_dq),
    .addr_q     (sram_addr),
    .wdata_q    (wdata_q),
    .rd_data_q  (rd_data),
    .rd_valid_q (rd_valid)
  );

  assign sram_ce_n = pins_q.ce_n;
  assign sram_oe_n = pins_q.oe_n;
  assign sram_we_n = pins_q.we_n;
  assign drv_en    = pins_q.drive;

  for (genvar b = 0; b < DATA_W; b++) begin : g_pad
    assign sram_dq[b] = drv_en ? wdata_q[b] : 1'bz;
  end

  // cycles the write strobe has been low, saturating, for the turnaround check
  logic [7:0] we_low_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) we_low_run <= '0;
    else if (sram_we_n) we_low_run <= '0;
    else if (we_low_run != 8'hFF) we_low_run <= we_low_run + 8'd1;
  end

  AST_IDLE_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> sram_ce_n && sram_oe_n && sram_we_n && !drv_en); // R1

  AST_WE_IN_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> !sram_ce_n && sram_oe_n); // R3

  AST_NO_DRIVE_WITH_OE: assert property (@(posedge clk) disable iff (!rst_n)
    drv_en |-> sram_oe_n); // R4

  AST_DRIVE_AFTER_TURN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv_en) |-> (we_low_run >= 8'(C_TURN))); // R4

  AST_WE_ENDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_we_n) |-> !sram_ce_n && drv_en); // R5

  AST_READ_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_oe_n |-> sram_we_n && !sram_ce_n); // R6

  AST_VALID_AFTER_OE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $rose(sram_oe_n)); // R7

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !ready && $past(!ready) |-> $stable(sram_addr)); // R9

endmodule

// File: tb/async_sram_ctrl_test.sv
`timescale 1ns/1ps
module async_sram_ctrl_test;

  // expected counts restated from the nanosecond figures at 5 ns per cycle (R10)
  localparam int P = 5;
  localparam int EXP_TURN  = (20 + P - 1) / P;
  localparam int EXP_SD    = ((25 + P - 1) / P > (40 + P - 1) / P - EXP_TURN) ?
                             (25 + P - 1) / P : (40 + P - 1) / P - EXP_TURN;
  localparam int EXP_WE    = EXP_TURN + EXP_SD;
  localparam int EXP_AS    = ((45 + P - 1) / P - EXP_WE < 1) ? 1 : (45 + P - 1) / P - EXP_WE;
  localparam int EXP_RD    = (55 + P - 1) / P;
  localparam int EXP_WBUSY = EXP_AS + EXP_WE + 1 +
                             (((55 + P - 1) / P - (EXP_AS + EXP_WE + 1) < 1) ? 1 :
                              (55 + P - 1) / P - (EXP_AS + EXP_WE + 1));
  localparam int EXP_RBUSY = EXP_RD + (((55 + P - 1) / P - EXP_RD > EXP_TURN) ?
                              (55 + P - 1) / P - EXP_RD : EXP_TURN);

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic        req_we = 1'b0;
  logic [14:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        ready, rd_valid;
  logic [7:0]  rd_data;
  logic [14:0] sram_addr;
  logic        sram_ce_n, sram_oe_n, sram_we_n;
  wire  [7:0]  dq;

  logic        mdl_en = 1'b0;
  logic [7:0]  mdl_q = '0;
  assign dq = mdl_en ? mdl_q : 8'bz;

  async_sram_ctrl uut (
    .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata), .ready(ready),
    .rd_valid(rd_valid), .rd_data(rd_data), .sram_addr(sram_addr),
    .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n),
    .sram_dq(dq)
  );

  always #2.5 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wrap_up();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  // ---------------- SRAM model ----------------
  logic [7:0] mdl_mem [int unsigned];
  function automatic logic [7:0] mdl_read(logic [14:0] a);
    return mdl_mem.exists(int'(a)) ? mdl_mem[int'(a)] : 8'h00;
  endfunction

  initial begin
    int age = 0;
    bit on = 1'b0;
    logic [14:0] last_a = '0;
    forever begin
      #1;
      if (!sram_ce_n && !sram_oe_n && sram_we_n) begin
        if (!on || sram_addr != last_a) age = 0; else age++;
        on = 1'b1;
        last_a = sram_addr;
        mdl_en = 1'b1;
        mdl_q = (age >= 50) ? mdl_read(sram_addr) : ~mdl_read(sram_addr);
      end else begin
        on = 1'b0;
        mdl_en = 1'b0;
      end
    end
  end

  logic [7:0] hist [5];
  always @(negedge clk) begin
    for (int i = 4; i > 0; i--) hist[i] = hist[i-1];
    hist[0] = dq;
  end

  always @(posedge sram_we_n) begin
    if (rst_n && !sram_ce_n) begin
      bit same = 1'b1;
      for (int i = 0; i < 5; i++) if (hist[i] != dq) same = 1'b0;
      chk(same, "R4 write byte stable before WE rise", int'(hist[4]), int'(dq));
      mdl_mem[int'(sram_addr)] = dq;
    end
  end

  // ---------------- scoreboard ----------------
  logic [7:0]  ref_mem [int unsigned];
  logic [7:0]  exp_q [$];
  bit          op_we_q [$];
  logic [14:0] op_addr_q [$];

  task automatic op(input bit we, input logic [14:0] a, input logic [7:0] d);
    req = 1'b1; req_we = we; req_addr = a; req_wdata = d;
    op_we_q.push_back(we);
    op_addr_q.push_back(a);
    if (we) ref_mem[int'(a)] = d;
    else exp_q.push_back(ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 8'h00);
    while (!ready) @(negedge clk);
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while ((!ready || exp_q.size() != 0) && n < 100) begin
      @(negedge clk);
      n++;
    end
    @(negedge clk);
  endtask

  // ---------------- monitor ----------------
  bit          prev_rdy = 1'b1, prev_we = 1'b1, prev_oe = 1'b1, prev_ce = 1'b1, prev_rdv = 1'b0;
  int          rdy_run = 0, we_run = 0, ce_run = 0, oe_run = 0, cyc = 0, we_rise_at = 0;
  bit          mon_we = 1'b0, addr_bad = 1'b0, we_bad = 1'b0;
  logic [14:0] mon_addr = '0;

  always @(negedge clk) begin
    if (rst_n && !done) begin
      cyc++;
      if (prev_rdy && !ready) begin
        if (op_we_q.size() > 0) begin
          mon_we = op_we_q.pop_front();
          mon_addr = op_addr_q.pop_front();
        end else chk(1'b0, "R2 unexpected accept", 1, 0);
        rdy_run = 0;
        addr_bad = 1'b0;
      end
      if (!ready) begin
        rdy_run++;
        if (sram_addr != mon_addr) addr_bad = 1'b1;
      end
      if (!prev_rdy && ready) begin
        chk(rdy_run == (mon_we ? EXP_WBUSY : EXP_RBUSY),
            mon_we ? "R8 write busy length" : "R8 read busy length",
            rdy_run, mon_we ? EXP_WBUSY : EXP_RBUSY);
        chk(!addr_bad, "R9 address held while busy", int'(sram_addr), int'(mon_addr));
        chk(sram_ce_n && sram_oe_n && sram_we_n, "R1 idle strobes high",
            int'({sram_ce_n, sram_oe_n, sram_we_n}), 7);
      end
      // write strobe
      if (!sram_we_n && prev_we) begin
        chk(ce_run == EXP_AS, "R3 select leads write strobe", ce_run, EXP_AS);
        we_run = 0;
      end
      if (!sram_we_n) begin
        we_run++;
        if (!sram_oe_n || sram_ce_n) we_bad = 1'b1;
      end
      if (sram_we_n && !prev_we) begin
        chk(we_run == EXP_WE, "R3 R10 write strobe width", we_run, EXP_WE);
        chk(!we_bad, "R3 OE high and CE low during write", 1, 0);
        we_bad = 1'b0;
        we_rise_at = cyc;
      end
      // select
      if (!sram_ce_n) ce_run++;
      if (sram_ce_n && !prev_ce) begin
        if (mon_we) chk(cyc - we_rise_at == 1, "R5 select rises one cycle after WE",
                        cyc - we_rise_at, 1);
        ce_run = 0;
      end
      // output enable
      if (!sram_oe_n) oe_run++;
      if (sram_oe_n && !prev_oe) begin
        chk(oe_run == EXP_RD, "R6 R10 read access window", oe_run, EXP_RD);
        chk(rd_valid, "R7 valid with OE rise", int'(rd_valid), 1);
        oe_run = 0;
      end
      if (rd_valid) begin
        chk(!prev_rdv, "R7 valid single cycle", int'(prev_rdv), 0);
        if (exp_q.size() > 0) begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(rd_data == e, "R6 read data", int'(rd_data), int'(e));
        end else chk(1'b0, "R7 unexpected valid", 1, 0);
      end
      prev_rdy = ready; prev_we = sram_we_n; prev_oe = sram_oe_n;
      prev_ce = sram_ce_n; prev_rdv = rd_valid;
    end
  end

  // ---------------- watchdog ----------------
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      chk(1'b0, "watchdog expired", 0, 1);
      wrap_up();
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [14:0] a;
    logic [7:0]  v;
    repeat (3) @(negedge clk);
    chk(ready && sram_ce_n && sram_oe_n && sram_we_n && !rd_valid, "R1 reset state",
        int'({ready, sram_ce_n, sram_oe_n, sram_we_n, rd_valid}), 5'b11110);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(ready && sram_ce_n && sram_oe_n && sram_we_n, "R1 idle after reset",
        int'({ready, sram_ce_n, sram_oe_n, sram_we_n}), 4'hF);

    // writes across the address range, then back-to-back reads
    op(1'b1, 15'h0000, 8'hA5);
    op(1'b1, 15'h7FFF, 8'h5A);
    op(1'b1, 15'h1234, 8'hFF);
    op(1'b1, 15'h4321, 8'h00);
    op(1'b1, 15'h0001, 8'h81);
    op(1'b0, 15'h0000, 8'h00);
    op(1'b0, 15'h7FFF, 8'h00);
    op(1'b0, 15'h1234, 8'h00);
    op(1'b0, 15'h4321, 8'h00);
    op(1'b0, 15'h0001, 8'h00);
    // read then write then read (turnaround both ways)
    op(1'b1, 15'h0001, 8'h3C);
    op(1'b0, 15'h0001, 8'h00);
    op(1'b1, 15'h7FFF, 8'hC3);
    op(1'b0, 15'h7FFF, 8'h00);
    wait_idle();

    // R2: a short pulse during a busy write must be ignored
    op(1'b1, 15'h2AAA, 8'h66);
    op(1'b1, 15'h1555, 8'h11);
    repeat (2) @(negedge clk);
    req = 1'b1; req_we = 1'b1; req_addr = 15'h2AAA; req_wdata = 8'h99;
    @(negedge clk);
    req = 1'b0;
    wait_idle();
    op(1'b0, 15'h2AAA, 8'h00);
    wait_idle();
    chk(rd_data == 8'h66, "R2 busy request ignored", int'(rd_data), 8'h66);
    repeat (5) @(negedge clk);
    chk(!rd_valid && rd_data == 8'h66, "R7 read data kept", int'(rd_data), 8'h66);

    // mixed traffic
    for (int i = 0; i < 24; i++) begin
      a = 15'((i * 1237 + 91) & 16'h7FFF);
      v = 8'((i * 29) ^ 8'h4B);
      op(1'b1, a, v);
      if (i % 3 == 0) op(1'b0, a, 8'h00);
    end
    for (int i = 0; i < 24; i += 5) op(1'b0, 15'((i * 1237 + 91) & 16'h7FFF), 8'h00);
    wait_idle();
    chk(exp_q.size() == 0, "R6 all reads returned", exp_q.size(), 0);

    done = 1'b1;
    wrap_up();
  end

endmodule